// File: doc/BRIEF.md
# Two-Entry Controller Command Queue

This block sits between a host register write port and the sequencer of a bus controller. The host writes 8-bit commands. Each command is split into a DMA request flag (bit 7) and a 7-bit operation code whose bits 6:4 give its mode class. The class is checked against the controller's present bus role: disconnected, initiator or target. A legal command goes into a two-entry queue. The head of the queue is offered to the sequencer over a valid/ready handshake.

An illegal command never enters the queue. It produces a one-cycle illegal-command pulse instead. Because the queue has two entries, the host can write a second command while the first is still waiting for the sequencer. A chip-reset command is handled in the queue itself: it clears every pending entry and is not passed on.

Top module: `cmdq_top`

## Requirements
- R1: After reset, `cmd_valid` and `illegal_cmd` are both 0.
- R2: An issued command shows bit 7 of the written byte on `cmd_dma` and bits 6:0 on `cmd_code`.
- R3: Legality depends on bits 6:4 and the role. Class 000 is legal in every role. Class 100 is legal only in role 0 (disconnected). Class 001 is legal only in role 1 (initiator). Class 010 is legal only in role 2 (target). Every other class is never legal, and role 3 accepts only class 000.
- R4: An illegal write leaves the queue unchanged. It raises `illegal_cmd` for exactly the one cycle after the write's clock edge.
- R5: Commands leave in write order, one on each clock edge where `cmd_valid` and `cmd_ready` are both high. A written command becomes visible in the cycle after its write edge.
- R6: The queue holds two entries. A legal write into a full queue, with no pop on the same edge, replaces the newest entry.
- R7: A legal write into a full queue on the same edge as a pop is stored behind the remaining entry, so nothing is lost.
- R8: A write whose bits 6:0 equal 0x02 (chip reset, with either value of bit 7) empties the queue. It is not queued and raises no illegal pulse.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the head command stays stable unless a chip-reset write arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host command write strobe |
| wr_data | input | 8 | Command byte written by the host |
| bus_role | input | 2 | Current role: 0 disconnected, 1 initiator, 2 target |
| cmd_ready | input | 1 | Sequencer accepts the head command |
| cmd_valid | output | 1 | A command is pending at the head |
| cmd_dma | output | 1 | DMA flag of the head command |
| cmd_code | output | 7 | Operation code of the head command |
| illegal_cmd | output | 1 | One-cycle pulse for a rejected command |

## Verification
The directed patterns cover the following cases:
- One class written under each of the four roles, which separates the class-to-role matching from a check that only looks for any class bit set.
- Back-to-back writes with the sequencer stalled, which separates overwrite-newest from dropping the newest write or overwriting the head.
- A write into a full queue on the same edge as a pop, which shows whether the shift and the push are combined correctly.
- A chip-reset byte with the DMA bit set, which shows whether the reset decode ignores bit 7.

A long random run mixes all of these with random ready and role values. The bench model is checked against the outputs on every cycle.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
    localparam int CMD_W  = 8;
    localparam int CODE_W = CMD_W - 1;
    localparam logic [CODE_W-1:0] OP_CHIP_RESET = 7'h02;

    typedef enum logic [1:0] {
        ROLE_IDLE = 2'd0,
        ROLE_INIT = 2'd1,
        ROLE_TARG = 2'd2,
        ROLE_NONE = 2'd3
    } role_e;

    typedef enum logic [2:0] {
        CLS_MISC = 3'b000,
        CLS_INIT = 3'b001,
        CLS_TARG = 3'b010,
        CLS_IDLE = 3'b100
    } cls_e;

    typedef struct packed {
        logic              dma;
        logic [CODE_W-1:0] code;
    } cmd_t;

    function automatic cmd_t split_cmd(input logic [CMD_W-1:0] b);
        cmd_t c;
        c.dma  = b[CMD_W-1];
        c.code = b[CODE_W-1:0];
        return c;
    endfunction

    function automatic logic class_ok(input logic [2:0] cls, input role_e r);
        logic ok;
        case (cls)
            CLS_MISC: ok = 1'b1;
            CLS_IDLE: ok = (r == ROLE_IDLE);
            CLS_INIT: ok = (r == ROLE_INIT);
            CLS_TARG: ok = (r == ROLE_TARG);
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/cmdq_decode.sv
module cmdq_decode
    import cmdq_pkg::*;
(
    input  logic [CMD_W-1:0] byte_in,
    input  role_e            role,
    output cmd_t             cmd,
    output logic             legal,
    output logic             chip_reset
);
    always_comb begin
        cmd        = split_cmd(byte_in);
        legal      = class_ok(cmd.code[CODE_W-1:CODE_W-3], role);
        chip_reset = (cmd.code == OP_CHIP_RESET);
    end
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  cmd_t push_cmd,
    input  logic pop,
    input  logic flush,
    output logic not_empty,
    output cmd_t head
);
    localparam int CW = $clog2(DEPTH + 1);

    cmd_t          ent   [DEPTH];
    cmd_t          ent_n [DEPTH];
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_n[i] = ent[i];
        cnt_n = cnt;
        if (flush) begin
            cnt_n = '0;
        end else begin
            if (pop && cnt != '0) begin
                for (int i = 0; i < DEPTH - 1; i++) ent_n[i] = ent[i + 1];
                cnt_n = cnt - 1'b1;
            end
            if (push) begin
                if (cnt_n == CW'(DEPTH)) begin
                    ent_n[DEPTH-1] = push_cmd;
                end else begin
                    for (int i = 0; i < DEPTH; i++)
                        if (CW'(i) == cnt_n) ent_n[i] = push_cmd;
                    cnt_n = cnt_n + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            cnt <= cnt_n;
            for (int i = 0; i < DEPTH; i++) ent[i] <= ent_n[i];
        end
    end

    assign not_empty = (cnt != '0);
    assign head      = ent[0];
endmodule

// File: rtl/cmdq_top.sv
module cmdq_top
    import cmdq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [1:0]       bus_role,
    input  logic             cmd_ready,
    output logic             cmd_valid,
    output logic             cmd_dma,
    output logic [CODE_W-1:0] cmd_code,
    output logic             illegal_cmd
);
    cmd_t dec_cmd, head;
    logic dec_legal, dec_reset, ill_q;

    cmdq_decode u_dec (
        .byte_in    (wr_data),
        .role       (role_e'(bus_role)),
        .cmd        (dec_cmd),
        .legal      (dec_legal),
        .chip_reset (dec_reset)
    );

    cmdq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_en && dec_legal && !dec_reset),
        .push_cmd  (dec_cmd),
        .pop       (cmd_ready),
        .flush     (wr_en && dec_reset),
        .not_empty (cmd_valid),
        .head      (head)
    );

    always_ff @(posedge clk) begin
        if (rst) ill_q <= 1'b0;
        else     ill_q <= wr_en && !dec_legal;
    end

    assign cmd_dma     = head.dma;
    assign cmd_code    = head.code;
    assign illegal_cmd = ill_q;
endmodule

// File: rtl/cmdq_chk.sv
module cmdq_chk
    import cmdq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CMD_W-1:0] wr_data,
    input logic             cmd_ready,
    input logic             cmd_valid,
    input logic             cmd_dma,
    input logic [CODE_W-1:0] cmd_code,
    input logic             illegal_cmd
);
    assert_rst_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!cmd_valid && !illegal_cmd));

    assert_ill_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        illegal_cmd |-> $past(wr_en));

    assert_ill_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (illegal_cmd && !wr_en) |=> !illegal_cmd);

    assert_valid_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && !wr_en) |=> !cmd_valid);

    assert_reset_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[CODE_W-1:0] == OP_CHIP_RESET) |=> (!cmd_valid && !illegal_cmd));

    assert_head_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !(wr_en && wr_data[CODE_W-1:0] == OP_CHIP_RESET))
        |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_dma)));
endmodule

bind cmdq_top cmdq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cmd_ready   (cmd_ready),
    .cmd_valid   (cmd_valid),
    .cmd_dma     (cmd_dma),
    .cmd_code    (cmd_code),
    .illegal_cmd (illegal_cmd)
);

// File: tb/sim_cmdq_top.sv
module sim_cmdq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] bus_role = 2'd0;
    logic       cmd_ready = 1'b0;
    logic       cmd_valid, cmd_dma, illegal_cmd;
    logic [6:0] cmd_code;

    int checks = 0;
    int errors = 0;
    logic [7:0] q[$];
    logic       exp_ill = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    cmdq_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .bus_role(bus_role), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
        .cmd_dma(cmd_dma), .cmd_code(cmd_code), .illegal_cmd(illegal_cmd)
    );

    function automatic bit ref_legal(input logic [7:0] d, input logic [1:0] r);
        case (d[6:4])
            3'b000:  return 1'b1;
            3'b100:  return r == 2'd0;
            3'b001:  return r == 2'd1;
            3'b010:  return r == 2'd2;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req);
        checks++;
        if (cmd_valid !== (q.size() > 0)) begin
            errors++;
            $display("FAIL %s valid actual %0b expected %0b", req, cmd_valid, q.size() > 0);
        end else if (q.size() > 0 && {cmd_dma, cmd_code} !== q[0]) begin
            errors++;
            $display("FAIL %s head actual %h expected %h", req, {cmd_dma, cmd_code}, q[0]);
        end
        checks++;
        if (illegal_cmd !== exp_ill) begin
            errors++;
            $display("FAIL %s illegal actual %0b expected %0b", req, illegal_cmd, exp_ill);
        end
    endtask

    task automatic step(input bit we, input logic [7:0] d, input logic [1:0] r,
                        input bit rdy, input string req);
        bit pop, lg;
        wr_en = we; wr_data = d; bus_role = r; cmd_ready = rdy;
        @(posedge clk);
        pop = (q.size() > 0) && rdy;
        lg  = ref_legal(d, r);
        exp_ill = we && !lg;
        if (we && d[6:0] == 7'h02) begin
            q.delete();
        end else begin
            if (pop) void'(q.pop_front());
            if (we && lg) begin
                if (q.size() == 2) q[1] = d;
                else q.push_back(d);
            end
        end
        @(negedge clk);
        check(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1");
        // R2 R5: write a DMA select in disconnected role, then accept it
        step(1, 8'hC2, 2'd0, 0, "R2");
        step(0, 8'h00, 2'd0, 1, "R5");
        // R3: each class against each role
        for (int r = 0; r < 4; r++) begin
            step(1, 8'h41, 2'(r), 1, "R3");
            step(1, 8'h11, 2'(r), 1, "R3");
            step(1, 8'h22, 2'(r), 1, "R3");
            step(1, 8'h81, 2'(r), 1, "R3");
            step(1, 8'h30, 2'(r), 1, "R3");
            step(0, 8'h00, 2'(r), 1, "R3");
        end
        // R4: illegal write on an occupied queue
        step(1, 8'h10, 2'd1, 0, "R4");
        step(1, 8'h20, 2'd1, 0, "R4");
        step(0, 8'h00, 2'd1, 0, "R4");
        // R6 R9: fill while stalled, then overwrite newest
        step(1, 8'h12, 2'd1, 0, "R6");
        step(1, 8'h9A, 2'd1, 0, "R6");
        step(1, 8'h1B, 2'd1, 0, "R9");
        // R7: write into full queue while popping
        step(1, 8'h00, 2'd1, 1, "R7");
        step(0, 8'h00, 2'd1, 1, "R5");
        step(0, 8'h00, 2'd1, 1, "R5");
        // R8: chip reset with DMA bit on a full queue
        step(1, 8'h01, 2'd2, 0, "R8");
        step(1, 8'h2A, 2'd2, 0, "R8");
        step(1, 8'h82, 2'd2, 0, "R8");
        step(1, 8'h02, 2'd2, 1, "R8");
        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            if ($urandom_range(0, 9) == 0) d[6:0] = 7'h02;
            step(1'($urandom_range(0, 2) != 0), d, 2'($urandom), 1'($urandom),
                 "R5");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL R5 watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule